// File: doc/BRIEF.md
# Linear-to-Physical Page Table Walker

This block turns a linear address into a physical address by reading page-table entries one at a time through a simple read port. On a start pulse it takes a snapshot of the address and of the paging controls. These are paging enable, physical-address extension, large-page enable, 5-level enable, the long-mode-active flag and the A20 gate. The controls select one of five walk shapes. The walk ends with a one-cycle done pulse that carries the physical address and a page-size code, or a fault flag.

The walker serves a single requester. It is used the way a miss handler uses its walk engine: the requester waits for done and then consumes the result. Permission bits, accessed/dirty updates and result caching belong to other blocks. The memory side answers each request with one response, which may arrive any number of cycles later.

Top module: `lin2phys_walker`

## Requirements
- R1: With paging disabled the walker makes no read and pulses done in the cycle after start. The result is the linear address, with bit 20 cleared when A20 is gated off, truncated to PA_W bits. The page size is 4 KB and fault is low.
- R2: The walk shape is decoded from the controls. Paging on without extension gives legacy 2-level. Extension on without long mode gives 3-level. Extension and long mode give 4-level, or 5-level when the 5-level enable is also set. A complete 4 KB walk takes 2, 3, 4 or 5 reads in these shapes.
- R3: In legacy walks the directory entry is read at (cr3 with bits 11:0 cleared) + 4 x linear bits 31:22. The table entry is read at (directory frame) + 4 x linear bits 21:12. Both reads are narrow (mem_wide=0), and the 4-byte entry comes back in the low half of mem_rdata. The result is entry bits 31:12 followed by linear bits 11:0.
- R4: In a legacy walk, a directory entry with bit 7 set while large pages are enabled ends the walk as a 4 MB page (code 2). The result is physical bits 39:32 from entry bits 20:13, bits 31:22 from entry bits 31:22, and bits 21:0 from the linear address. With large pages disabled, bit 7 is ignored and the walk continues to the table.
- R5: In 3-level walks the first read is at (cr3 with bits 4:0 cleared) + 8 x linear bits 31:30. Bit 7 in that first entry is ignored. The next levels use 9-bit indices from bits 29:21 and 20:12 with 8-byte entries (mem_wide=1). Bit 7 in the second-level entry gives a 2 MB page (code 1).
- R6: Long walks start with the index in linear bits 47:39, or in bits 56:48 for 5-level, and take 9 bits per level. Entry frames use bits PA_W-1:12 only. Bit 7 at the level that indexes bits 38:30 gives a 1 GB page (code 3). Bit 7 at the level that indexes bits 29:21 gives a 2 MB page.
- R7: In a 4-level walk, bits 63:48 must all equal bit 47. In a 5-level walk, bits 63:57 must all equal bit 56. If they do not, done and fault follow start in the next cycle with no read.
- R8: A fetched entry with bit 0 clear ends the walk with fault set and physical address 0, and no further read is made.
- R9: When A20 is gated off, bit 20 of every entry address is forced to 0, and so is bit 20 of a legacy 4 KB result frame. Results of 3-level and long walks are not masked.
- R10: At most one read is outstanding. mem_req is high for one cycle per read and only while busy. Start is ignored while busy. done is high for exactly one cycle per accepted start. The page-size codes are 0=4 KB, 1=2 MB, 2=4 MB and 3=1 GB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| lin_addr | input | 64 | Linear address to translate |
| cr3 | input | PA_W | Table root address |
| pg_en | input | 1 | Paging enable |
| pae_en | input | 1 | Physical-address extension enable |
| pse_en | input | 1 | Legacy 4 MB page enable |
| la57_en | input | 1 | 5-level enable |
| lma | input | 1 | Long mode active |
| a20_en | input | 1 | A20 gate open (0 clears address bit 20) |
| mem_req | output | 1 | Read request, one cycle |
| mem_addr | output | PA_W | Entry address |
| mem_wide | output | 1 | 1 = 8-byte read, 0 = 4-byte read |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 64 | Read response data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk failed (valid with done) |
| phys_addr | output | PA_W | Translated address (valid with done) |
| page_size | output | 2 | Page size code (valid with done) |

## Verification
The bench builds the walker with PA_W set to 40. With that width, the top bits of a legacy 4 MB frame (39:32) land exactly on the top result bits. Entry bits at 40 and above, including bit 63, must be dropped from frames. Read latency runs at one cycle and also at three cycles. The longer latency leaves room for a start pulse to arrive in the middle of a walk, and for the one-outstanding-read rule to be observed.

// File: rtl/walk_pkg.sv
// Shared types and constants for the linear-to-physical walker.
package walk_pkg;

    localparam int LIN_W   = 64;  // linear address width
    localparam int ENT_W   = 64;  // widest table entry
    localparam int LVL_W   = 3;   // holds level numbers 0..5
    localparam int A20_BIT = 20;
    localparam int BIG_BIT = 7;   // large-page flag inside an entry
    localparam int PRS_BIT = 0;   // present flag inside an entry

    typedef enum logic [2:0] {
        WM_OFF,
        WM_LEG,
        WM_PAE,
        WM_LONG4,
        WM_LONG5
    } walk_mode_t;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_4M = 2'd2,
        PG_1G = 2'd3
    } page_size_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT
    } walk_state_t;

endpackage

// File: rtl/walk_mode_dec.sv
// Decodes the paging controls into a walk shape and its first level, and
// checks that the upper linear bits are sign copies for long walks.
// Assumes the caller samples the outputs only in the cycle it accepts start.
module walk_mode_dec
    import walk_pkg::*;
(
    input  logic              pg,
    input  logic              pae,
    input  logic              lma,
    input  logic              la57,
    input  logic [63:47]      lin_hi,
    output walk_mode_t        mode,
    output logic [LVL_W-1:0]  first_lvl,
    output logic              canon_ok
);

    // Shape selection from control bits (R2).
    always_comb begin
        if (!pg)            mode = WM_OFF;
        else if (!pae)      mode = WM_LEG;
        else if (!lma)      mode = WM_PAE;
        else if (!la57)     mode = WM_LONG4;
        else                mode = WM_LONG5;
    end

    // Starting level and sign-extension test per shape (R7).
    always_comb begin
        first_lvl = '0;
        canon_ok  = 1'b1;
        case (mode)
            WM_LEG:   first_lvl = 3'd2;
            WM_PAE:   first_lvl = 3'd3;
            WM_LONG4: begin
                first_lvl = 3'd4;
                canon_ok  = (&lin_hi[63:47]) | ~(|lin_hi[63:47]);
            end
            WM_LONG5: begin
                first_lvl = 3'd5;
                canon_ok  = (&lin_hi[63:56]) | ~(|lin_hi[63:56]);
            end
            default:  first_lvl = '0;
        endcase
    end

endmodule

// File: rtl/walk_entry_addr.sv
// Forms the address of the next table entry from the current base, level
// and linear address, and applies the A20 gate. Assumes PA_W < 64 and a
// base that is either the root or a frame taken from the previous entry.
module walk_entry_addr
    import walk_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  walk_mode_t        mode,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [PA_W-1:0]   base,
    input  logic [LIN_W-1:0]  lin,
    input  logic              a20_en,
    output logic [PA_W-1:0]   addr,
    output logic              wide
);

    localparam int PAD_W = LIN_W - PA_W;

    logic [63:0] base64;
    logic [63:0] raw;
    logic [8:0]  idx9;

    assign base64 = {{PAD_W{1'b0}}, base};

    // Index extraction and aligned-base combination per shape (R3, R5, R6).
    always_comb begin
        idx9 = 9'(lin >> (7'd3 + 7'(lvl) * 7'd9));
        wide = 1'b1;
        case (mode)
            WM_LEG: begin
                wide = 1'b0;
                if (lvl == 3'd2)
                    raw = (base64 & ~64'hFFF) | 64'({lin[31:22], 2'b00});
                else
                    raw = (base64 & ~64'hFFF) | 64'({lin[21:12], 2'b00});
            end
            WM_PAE: begin
                if (lvl == 3'd3)
                    raw = (base64 & ~64'h1F) | 64'({lin[31:30], 3'b000});
                else
                    raw = (base64 & ~64'hFFF) | 64'({idx9, 3'b000});
            end
            default: raw = (base64 & ~64'hFFF) | 64'({idx9, 3'b000});
        endcase
        // A20 gate on every entry address (R9).
        if (!a20_en)
            raw[A20_BIT] = 1'b0;
    end

    assign addr = raw[PA_W-1:0];

endmodule

// File: rtl/walk_leaf_eval.sv
// Inspects a returned entry: present flag, whether it ends the walk, the
// page size, the composed physical address and the next-level base.
// Assumes PA_W >= 32 so legacy frames fit.
module walk_leaf_eval
    import walk_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  walk_mode_t        mode,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [ENT_W-1:0]  entry,
    input  logic              pse,
    input  logic              a20_en,
    input  logic [LIN_W-1:0]  lin,
    output logic              present,
    output logic              leaf,
    output page_size_t        psize,
    output logic [PA_W-1:0]   phys,
    output logic [PA_W-1:0]   next_base
);

    localparam logic [63:0] FRAME_MASK = ((64'd1 << PA_W) - 64'd1) & ~64'hFFF;

    logic [63:0] ent;
    logic [63:0] frame;
    logic [63:0] frame_sel;
    logic [63:0] off_mask;
    logic [63:0] phys64;
    logic        big;

    // Narrow entries use the low half only; frames drop bits above PA_W (R6).
    assign ent     = (mode == WM_LEG) ? {32'd0, entry[31:0]} : entry;
    assign frame   = ent & FRAME_MASK;
    assign present = ent[PRS_BIT];
    assign big     = ent[BIG_BIT];

    // Leaf decision, page size and frame choice per shape (R3-R6, R9).
    always_comb begin
        leaf      = 1'b0;
        psize     = PG_4K;
        off_mask  = 64'hFFF;
        frame_sel = frame;
        case (mode)
            WM_LEG: begin
                if (lvl == 3'd1) begin
                    leaf = 1'b1;
                    if (!a20_en)
                        frame_sel[A20_BIT] = 1'b0;
                end else if (big && pse) begin
                    leaf      = 1'b1;
                    psize     = PG_4M;
                    off_mask  = 64'h3F_FFFF;
                    frame_sel = {24'd0, ent[20:13], ent[31:22], 22'd0};
                end
            end
            WM_PAE, WM_LONG4, WM_LONG5: begin
                if (lvl == 3'd1) begin
                    leaf = 1'b1;
                end else if (lvl == 3'd2 && big) begin
                    leaf     = 1'b1;
                    psize    = PG_2M;
                    off_mask = 64'h1F_FFFF;
                end else if (lvl == 3'd3 && big && mode != WM_PAE) begin
                    leaf     = 1'b1;
                    psize    = PG_1G;
                    off_mask = 64'h3FFF_FFFF;
                end
            end
            default: leaf = 1'b0;
        endcase
    end

    assign phys64    = (frame_sel & ~off_mask) | (lin & off_mask);
    assign phys      = phys64[PA_W-1:0];
    assign next_base = frame[PA_W-1:0];

endmodule

// File: rtl/lin2phys_walker.sv
// Page table walker: accepts a start when idle, snapshots the controls,
// issues one entry read at a time and reports the physical address, page
// size or a fault with a one-cycle done pulse. Assumes the memory side
// returns exactly one response per request.
module lin2phys_walker
    import walk_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [63:0]       lin_addr,
    input  logic [PA_W-1:0]   cr3,
    input  logic              pg_en,
    input  logic              pae_en,
    input  logic              pse_en,
    input  logic              la57_en,
    input  logic              lma,
    input  logic              a20_en,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    output logic              mem_wide,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [PA_W-1:0]   phys_addr,
    output logic [1:0]        page_size
);

    walk_state_t        state;
    walk_mode_t         mode_q;
    logic [LVL_W-1:0]   level_q;
    logic [PA_W-1:0]    base_q;
    logic [LIN_W-1:0]   lin_q;
    logic               pse_q;
    logic               a20_q;
    logic               done_q;
    logic               fault_q;
    logic [PA_W-1:0]    phys_q;
    page_size_t         psize_q;

    walk_mode_t         dec_mode;
    logic [LVL_W-1:0]   dec_first;
    logic               dec_canon;
    logic [LIN_W-1:0]   lin_gated;

    logic               lf_present;
    logic               lf_leaf;
    page_size_t         lf_psize;
    logic [PA_W-1:0]    lf_phys;
    logic [PA_W-1:0]    lf_next;

    walk_mode_dec u_mode_dec (
        .pg        (pg_en),
        .pae       (pae_en),
        .lma       (lma),
        .la57      (la57_en),
        .lin_hi    (lin_addr[63:47]),
        .mode      (dec_mode),
        .first_lvl (dec_first),
        .canon_ok  (dec_canon)
    );

    walk_entry_addr #(.PA_W(PA_W)) u_entry_addr (
        .mode   (mode_q),
        .lvl    (level_q),
        .base   (base_q),
        .lin    (lin_q),
        .a20_en (a20_q),
        .addr   (mem_addr),
        .wide   (mem_wide)
    );

    walk_leaf_eval #(.PA_W(PA_W)) u_leaf_eval (
        .mode      (mode_q),
        .lvl       (level_q),
        .entry     (mem_rdata),
        .pse       (pse_q),
        .a20_en    (a20_q),
        .lin       (lin_q),
        .present   (lf_present),
        .leaf      (lf_leaf),
        .psize     (lf_psize),
        .phys      (lf_phys),
        .next_base (lf_next)
    );

    // Paging-off result: linear address through the A20 gate (R1, R9).
    always_comb begin
        lin_gated = lin_addr;
        if (!a20_en)
            lin_gated[A20_BIT] = 1'b0;
    end

    // Walk sequencer: accept, read, evaluate, descend or finish (R1-R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mode_q  <= WM_OFF;
            level_q <= '0;
            base_q  <= '0;
            lin_q   <= '0;
            pse_q   <= 1'b0;
            a20_q   <= 1'b1;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            phys_q  <= '0;
            psize_q <= PG_4K;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        lin_q  <= lin_addr;
                        mode_q <= dec_mode;
                        pse_q  <= pse_en;
                        a20_q  <= a20_en;
                        if (dec_mode == WM_OFF) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b0;
                            phys_q  <= lin_gated[PA_W-1:0];
                            psize_q <= PG_4K;
                        end else if (!dec_canon) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            phys_q  <= '0;
                            psize_q <= PG_4K;
                        end else begin
                            level_q <= dec_first;
                            base_q  <= cr3;
                            state   <= ST_REQ;
                        end
                    end
                end
                ST_REQ: state <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        if (!lf_present) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b1;
                            phys_q  <= '0;
                            psize_q <= PG_4K;
                            state   <= ST_IDLE;
                        end else if (lf_leaf) begin
                            done_q  <= 1'b1;
                            fault_q <= 1'b0;
                            phys_q  <= lf_phys;
                            psize_q <= lf_psize;
                            state   <= ST_IDLE;
                        end else begin
                            base_q  <= lf_next;
                            level_q <= level_q - 3'd1;
                            state   <= ST_REQ;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req   = (state == ST_REQ);
    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign fault     = fault_q;
    assign phys_addr = phys_q;
    assign page_size = psize_q;

endmodule

// File: rtl/walk_checker.sv
// Protocol and outcome properties of the walker, attached by bind.
// Assumes the memory side answers only a pending request.
module walk_checker #(
    parameter int PA_W = 52
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [63:47] lin_hi,
    input logic         pg_en,
    input logic         pae_en,
    input logic         la57_en,
    input logic         lma,
    input logic         a20_en,
    input logic         mem_req,
    input logic         addr_bit20,
    input logic         mem_rvalid,
    input logic         rdata_bit0,
    input logic         busy,
    input logic         done,
    input logic         fault,
    input logic [1:0]   page_size
);

    logic outst;
    logic a20_lat;
    logic long4_bad;

    // Tracks a request that has not yet been answered.
    always_ff @(posedge clk) begin
        if (!rst_n)           outst <= 1'b0;
        else if (mem_req)     outst <= 1'b1;
        else if (mem_rvalid)  outst <= 1'b0;
    end

    // Remembers the A20 gate of the accepted walk.
    always_ff @(posedge clk) begin
        if (!rst_n)              a20_lat <= 1'b1;
        else if (start && !busy) a20_lat <= a20_en;
    end

    assign long4_bad = pg_en && pae_en && lma && !la57_en &&
                       !((&lin_hi[63:47]) | ~(|lin_hi[63:47]));

    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !outst);

    a_r10_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    a_r10_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r1_off_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !pg_en) |=> (done && !fault && page_size == 2'd0));

    a_r7_noncanon_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && long4_bad) |=> (done && fault));

    a_r8_absent_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_rvalid && !rdata_bit0) |=> (done && fault));

    a_r9_a20_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !a20_lat) |-> !addr_bit20);

endmodule

bind lin2phys_walker walk_checker #(.PA_W(PA_W)) u_walk_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .lin_hi     (lin_addr[63:47]),
    .pg_en      (pg_en),
    .pae_en     (pae_en),
    .la57_en    (la57_en),
    .lma        (lma),
    .a20_en     (a20_en),
    .mem_req    (mem_req),
    .addr_bit20 (mem_addr[20]),
    .mem_rvalid (mem_rvalid),
    .rdata_bit0 (mem_rdata[0]),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .page_size  (page_size)
);

// File: tb/tb_lin2phys_walker.sv
module tb_lin2phys_walker;

    localparam int CLK_PERIOD = 10;
    localparam int PA_W       = 40;

    logic            clk;
    logic            rst_n;
    logic            start;
    logic [63:0]     lin_addr;
    logic [PA_W-1:0] cr3;
    logic            pg_en, pae_en, pse_en, la57_en, lma, a20_en;
    logic            mem_req;
    logic [PA_W-1:0] mem_addr;
    logic            mem_wide;
    logic            mem_rvalid;
    logic [63:0]     mem_rdata;
    logic            busy, done, fault;
    logic [PA_W-1:0] phys_addr;
    logic [1:0]      page_size;

    logic [63:0] mem [logic [63:0]];
    int          lat;
    int          rd_cnt;
    logic [63:0] first_addr, last_addr;
    logic        saw_wide, saw_narrow;
    int          checks, fails;
    logic [63:0] r_phys;
    logic [1:0]  r_size;
    logic        r_fault;

    lin2phys_walker #(.PA_W(PA_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .lin_addr(lin_addr), .cr3(cr3),
        .pg_en(pg_en), .pae_en(pae_en), .pse_en(pse_en), .la57_en(la57_en),
        .lma(lma), .a20_en(a20_en), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_wide(mem_wide), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fault(fault), .phys_addr(phys_addr),
        .page_size(page_size)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] fetch(input logic [63:0] a, input logic w);
        logic [63:0] k = a & ~64'h7;
        logic [63:0] v = mem.exists(k) ? mem[k] : 64'd0;
        if (w) return v;
        return a[2] ? {32'd0, v[63:32]} : {32'd0, v[31:0]};
    endfunction

    task automatic put8(input logic [63:0] a, input logic [63:0] v);
        mem[a] = v;
    endtask

    task automatic put4(input logic [63:0] a, input logic [31:0] v);
        logic [63:0] k = a & ~64'h7;
        logic [63:0] w = mem.exists(k) ? mem[k] : 64'd0;
        if (a[2]) w[63:32] = v; else w[31:0] = v;
        mem[k] = w;
    endtask

    function automatic logic [63:0] lin4(input int i4, input int i3, input int i2,
                                         input int i1, input int off);
        return (64'(i4) << 39) | (64'(i3) << 30) | (64'(i2) << 21) |
               (64'(i1) << 12) | 64'(off);
    endfunction

    // Memory responder: samples requests and answers after lat cycles.
    initial begin
        int          cnt;
        logic [63:0] pend;
        cnt = 0;
        pend = '0;
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (cnt != 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = pend;
                end
            end else if (mem_req) begin
                rd_cnt++;
                if (rd_cnt == 1) first_addr = 64'(mem_addr);
                last_addr = 64'(mem_addr);
                if (mem_wide) saw_wide = 1'b1; else saw_narrow = 1'b1;
                pend = fetch(64'(mem_addr), mem_wide);
                cnt  = lat;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_ctl(input logic pg, input logic pae, input logic pse,
                           input logic l57, input logic lm, input logic a20);
        pg_en = pg; pae_en = pae; pse_en = pse; la57_en = l57; lma = lm; a20_en = a20;
    endtask

    task automatic walk(input logic [63:0] la, input logic [63:0] root);
        int n;
        @(negedge clk);
        lin_addr = la;
        cr3 = root[PA_W-1:0];
        rd_cnt = 0; saw_wide = 0; saw_narrow = 0;
        first_addr = '1; last_addr = '1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk("R10 done seen", 64'(done), 64'd1);
        r_phys = 64'(phys_addr); r_size = page_size; r_fault = fault;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; start = 1'b0; lin_addr = '0; cr3 = '0; lat = 1;
        set_ctl(0, 0, 0, 0, 0, 1);
        repeat (3) @(negedge clk);
        chk("R10 reset busy", 64'(busy), 64'd0);
        chk("R10 reset done", 64'(done), 64'd0);
        chk("R10 reset req", 64'(mem_req), 64'd0);
        chk("R10 reset phys", 64'(phys_addr), 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_off;
        set_ctl(0, 0, 0, 0, 0, 1);
        walk(64'h0000_00AB_CD1F_5678, 64'h0);
        chk("R1 off phys", r_phys, 64'hAB_CD1F_5678);
        chk("R1 off size", 64'(r_size), 64'd0);
        chk("R1 off reads", 64'(rd_cnt), 64'd0);
        chk("R1 off fault", 64'(r_fault), 64'd0);
        set_ctl(0, 0, 0, 0, 0, 0);
        walk(64'h0000_0000_0010_0ABC, 64'h0);
        chk("R9 off a20 phys", r_phys, 64'hABC);
    endtask

    task automatic t_legacy;
        set_ctl(1, 0, 0, 0, 0, 1);
        put4(64'h1004, 32'h0000_2001);
        put4(64'h200C, 32'h0055_5003);
        walk(64'h0040_3123, 64'h1000);
        chk("R3 leg phys", r_phys, 64'h55_5123);
        chk("R3 leg size", 64'(r_size), 64'd0);
        chk("R2 leg reads", 64'(rd_cnt), 64'd2);
        chk("R3 leg first addr", first_addr, 64'h1004);
        chk("R3 leg last addr", last_addr, 64'h200C);
        chk("R3 leg narrow", 64'({saw_narrow, saw_wide}), 64'b10);
    endtask

    task automatic t_legacy_big;
        set_ctl(1, 0, 1, 0, 0, 1);
        put4(64'h1008, 32'h00C0_A081);
        walk(64'h0080_1234, 64'h1000);
        chk("R4 4M phys", r_phys, 64'h5_00C0_1234);
        chk("R4 4M size", 64'(r_size), 64'd2);
        chk("R4 4M reads", 64'(rd_cnt), 64'd1);
        set_ctl(1, 0, 0, 0, 0, 1);
        put4(64'hC0A004, 32'h0077_7001);
        walk(64'h0080_1234, 64'h1000);
        chk("R4 pse off phys", r_phys, 64'h77_7234);
        chk("R4 pse off size", 64'(r_size), 64'd0);
        chk("R4 pse off reads", 64'(rd_cnt), 64'd2);
    endtask

    task automatic t_pae;
        set_ctl(1, 1, 0, 0, 0, 1);
        put8(64'h3028, 64'h4081);
        put8(64'h4018, 64'h5001);
        put8(64'h5010, 64'h12_3456_7001);
        walk(64'h4060_2345, 64'h3027);
        chk("R5 pae phys", r_phys, 64'h12_3456_7345);
        chk("R2 pae reads", 64'(rd_cnt), 64'd3);
        chk("R5 pae first addr", first_addr, 64'h3028);
        chk("R5 pae wide", 64'({saw_narrow, saw_wide}), 64'b01);
        put8(64'h3030, 64'h6001);
        put8(64'h6008, 64'h0AA0_0081);
        walk(64'h8020_0ABC, 64'h3020);
        chk("R5 pae 2M phys", r_phys, 64'h0AA0_0ABC);
        chk("R5 pae 2M size", 64'(r_size), 64'd1);
        chk("R5 pae 2M reads", 64'(rd_cnt), 64'd2);
    endtask

    task automatic t_long4;
        set_ctl(1, 1, 0, 0, 1, 1);
        put8(64'h10008, 64'h11003);
        put8(64'h11010, 64'h12001);
        put8(64'h12018, 64'h13001);
        put8(64'h13020, 64'h8000_FF98_7654_3001);
        walk(lin4(1, 2, 3, 4, 'h567), 64'h10000);
        chk("R6 l4 phys", r_phys, 64'h98_7654_3567);
        chk("R2 l4 reads", 64'(rd_cnt), 64'd4);
        chk("R6 l4 first addr", first_addr, 64'h10008);
        chk("R6 l4 last addr", last_addr, 64'h13020);
    endtask

    task automatic t_long_large;
        logic [63:0] la;
        set_ctl(1, 1, 0, 0, 1, 1);
        put8(64'h10028, 64'h14001);
        put8(64'h14038, 64'h80_4000_0081);
        la = lin4(5, 7, 'h12, 'h34, 'hABC);
        walk(la, 64'h10000);
        chk("R6 1G phys", r_phys, 64'h80_4000_0000 | (la & 64'h3FFF_FFFF));
        chk("R6 1G size", 64'(r_size), 64'd3);
        chk("R6 1G reads", 64'(rd_cnt), 64'd2);
        put8(64'h14040, 64'h15001);
        put8(64'h15048, 64'h12_3440_0081);
        la = lin4(5, 8, 9, 'h1F, 'h123);
        walk(la, 64'h10000);
        chk("R6 2M phys", r_phys, 64'h12_3440_0000 | (la & 64'h1F_FFFF));
        chk("R6 2M size", 64'(r_size), 64'd1);
        chk("R6 2M reads", 64'(rd_cnt), 64'd3);
    endtask

    task automatic t_long5;
        logic [63:0] la;
        set_ctl(1, 1, 0, 1, 1, 1);
        lat = 3;
        put8(64'h20018, 64'h21001);
        put8(64'h21008, 64'h22001);
        put8(64'h22010, 64'h23001);
        put8(64'h23018, 64'h24001);
        put8(64'h24020, 64'h55_5555_5001);
        la = (64'd3 << 48) | lin4(1, 2, 3, 4, 'h567);
        walk(la, 64'h20000);
        chk("R6 l5 phys", r_phys, 64'h55_5555_5567);
        chk("R2 l5 reads", 64'(rd_cnt), 64'd5);
        chk("R6 l5 first addr", first_addr, 64'h20018);
        lat = 1;
        set_ctl(1, 1, 0, 0, 1, 1);
        walk(la, 64'h20000);
        chk("R7 l4 on l5 addr fault", 64'(r_fault), 64'd1);
        chk("R7 l4 on l5 addr reads", 64'(rd_cnt), 64'd0);
    endtask

    task automatic t_canon;
        set_ctl(1, 1, 0, 0, 1, 1);
        walk(64'h0000_8000_0000_0000, 64'h10000);
        chk("R7 noncanon fault", 64'(r_fault), 64'd1);
        chk("R7 noncanon reads", 64'(rd_cnt), 64'd0);
        walk(64'hFFFF_8000_0000_0000, 64'h10000);
        chk("R7 neg canon reads", 64'(rd_cnt), 64'd1);
        chk("R7 neg canon addr", first_addr, 64'h10800);
        set_ctl(1, 1, 0, 1, 1, 1);
        walk(64'h0100_0000_0000_0000, 64'h20000);
        chk("R7 l5 noncanon fault", 64'(r_fault), 64'd1);
        chk("R7 l5 noncanon reads", 64'(rd_cnt), 64'd0);
    endtask

    task automatic t_absent;
        set_ctl(1, 1, 0, 0, 1, 1);
        walk(lin4(1, 2, 3, 6, 0), 64'h10000);
        chk("R8 absent fault", 64'(r_fault), 64'd1);
        chk("R8 absent reads", 64'(rd_cnt), 64'd4);
        chk("R8 absent phys", r_phys, 64'd0);
        set_ctl(1, 0, 0, 0, 0, 1);
        walk(64'h0C00_0000, 64'h1000);
        chk("R8 leg absent fault", 64'(r_fault), 64'd1);
        chk("R8 leg absent reads", 64'(rd_cnt), 64'd1);
    endtask

    task automatic t_a20;
        set_ctl(1, 0, 0, 0, 0, 0);
        walk(64'h0040_3123, 64'h10_1000);
        chk("R9 leg a20 first addr", first_addr, 64'h1004);
        chk("R9 leg a20 phys", r_phys, 64'h45_5123);
        set_ctl(1, 1, 0, 0, 1, 0);
        walk(lin4(1, 2, 3, 4, 'h567), 64'h11_0000);
        chk("R9 long a20 first addr", first_addr, 64'h10008);
        chk("R9 long result unmasked", r_phys, 64'h98_7654_3567);
    endtask

    task automatic t_busy_ignore;
        int n;
        set_ctl(1, 1, 0, 0, 1, 1);
        lat = 3;
        @(negedge clk);
        lin_addr = lin4(1, 2, 3, 4, 'h567);
        cr3 = 'h10000;
        rd_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        pg_en = 1'b0;
        lin_addr = 64'h1234;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk("R10 busy walk phys", 64'(phys_addr), 64'h98_7654_3567);
        chk("R10 busy walk reads", 64'(rd_cnt), 64'd4);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 single done", 64'(done), 64'd0);
        end
        lat = 1;
        pg_en = 1'b1;
    endtask

    // Global watchdog.
    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL R10 watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        checks = 0; fails = 0; rd_cnt = 0;
        t_reset();
        t_off();
        t_legacy();
        t_legacy_big();
        t_pae();
        t_long4();
        t_long_large();
        t_long5();
        t_canon();
        t_absent();
        t_a20();
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule